// File: doc/BRIEF.md
# Single-Shot Pulse-Width Capture Unit

This block sits beside a free-running counter and records the width of one narrow high pulse. Software picks one of several input sources, then sets an arm bit. The armed unit waits for a rising edge on the chosen source and then for the next falling edge. On that falling edge it copies the counter value into two capture registers, one for the rise and one for the fall, and clears its own arm bit. Each armed operation therefore yields exactly one result, and software reads the registers afterwards.

A separate general capture register copies the counter on every edge of the chosen source that matches a programmable edge filter. This happens whether or not the unit is armed. A completion flag records that a single-shot capture has finished. It drives an interrupt output when enabled, and software clears it by writing 0.

Top module: `pwcap_top`

## Requirements
- R1: After reset, every readable register (address 0 control, 1 general capture, 2 rise capture, 3 fall capture) reads 0 and `irq_o` is low.
- R2: A write to address 0 with bit 0 (arm) set to 1 arms the unit, and bit 0 reads back 1 while the unit is armed.
- R3: While the unit is armed, a falling edge seen before any rising edge is ignored: the unit stays armed and neither capture register at address 2 or 3 changes.
- R4: When a falling edge follows a detected rising edge while armed, the counter value is loaded into both the rise (address 2) and fall (address 3) capture registers. The value loaded is the one the counter holds at the third clock edge after the input falls (two synchronizer flops plus the edge stage).
- R5: When that capture completes, the arm bit clears to 0 by hardware and the done flag (address 0, bit 1) sets to 1.
- R6: `irq_o` is high exactly when the done flag and the interrupt enable (address 0, bit 2) are both 1. Writing 0 to bit 1 clears the done flag, and writing 1 to it leaves the flag unchanged.
- R7: If software writes 0 to the arm bit before the falling edge arrives, the operation is abandoned: neither capture register changes and the done flag does not set.
- R8: Address 0 bits [6:5] select the observed source from `src_i`. Edges on the other sources affect no register.
- R9: The general capture register (address 1) loads the counter on each edge of the selected source that matches address 0 bits [4:3] (00 none, 01 rising, 10 falling, 11 both), whether armed or not.
- R10: Once a capture completes, further pulses leave the rise and fall capture registers unchanged until the unit is armed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Free-running counter value |
| src_i | input | NUM_SRC | Candidate capture sources, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bench builds the unit with CNT_W = 12 and NUM_SRC = 4. It starts its counter just below 4095, so the counter wraps during the run and results are checked across the wrap. With four sources, the 2-bit select field covers every code, and pulses on unselected sources can be mixed with pulses on the selected one. Random pulse widths down to one clock, together with arm, disarm, filter and select changes, reach the early-fall, abandoned-arm and re-pulse-after-done orderings alongside the directed cases.

// File: rtl/pwcap_pkg.sv
`timescale 1ns/1ps
package pwcap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRISE = 2'd1,
    ST_WFALL = 2'd2
  } arm_state_e;

  // register addresses
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_GEN  = 2'd1;
  localparam logic [1:0] A_RISE = 2'd2;
  localparam logic [1:0] A_FALL = 2'd3;

  // control register bit positions
  localparam int unsigned B_START = 0;
  localparam int unsigned B_DONE  = 1;
  localparam int unsigned B_IE    = 2;
  localparam int unsigned B_GE    = 3;
  localparam int unsigned B_SEL   = 5;
endpackage

// File: rtl/pwcap_sync_edge.sv
`timescale 1ns/1ps
module pwcap_sync_edge #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               rise_o,
  output logic               fall_o
);
  logic              mux_lvl;
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  // source multiplexer
  always_comb begin
    mux_lvl = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel_i == SEL_W'(i)) mux_lvl = src_i[i];
    end
  end

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = mux_lvl;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], mux_lvl};
    end
  endgenerate

  assign prev_d = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign rise_o =  chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] &  prev_q;
endmodule

// File: rtl/pwcap_seq.sv
`timescale 1ns/1ps
module pwcap_seq
  import pwcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       ctrl_we_i,
  input  logic       wr_start_i,
  output arm_state_e st_o,
  output logic       cap_o
);
  arm_state_e st_q, st_d;

  assign cap_o = (st_q == ST_WFALL) && fall_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_WRISE: if (rise_i) st_d = ST_WFALL;
      ST_WFALL: if (fall_i) st_d = ST_IDLE;
      default:  st_d = st_q;
    endcase
    // software access; a completing capture takes precedence
    if (ctrl_we_i && !cap_o) begin
      if (!wr_start_i)            st_d = ST_IDLE;
      else if (st_q == ST_IDLE)   st_d = ST_WRISE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/pwcap_regs.sv
`timescale 1ns/1ps
module pwcap_regs
  import pwcap_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             cap_i,
  input  logic             armed_i,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic             ctrl_we_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             done_o,
  output logic [CNT_W-1:0] gen_o,
  output logic [CNT_W-1:0] rcap_o,
  output logic [CNT_W-1:0] fcap_o,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq_o
);
  logic             done_q, done_d;
  logic             ie_q, ie_d;
  logic [1:0]       ge_q, ge_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [CNT_W-1:0] gen_q, gen_d, rcap_q, rcap_d, fcap_q, fcap_d;
  logic             gen_en;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata[CNT_W-1:B_SEL+SEL_W];
  assign ctrl_we_o    = reg_we && (reg_addr == A_CTRL);
  assign gen_en       = (rise_i & ge_q[0]) | (fall_i & ge_q[1]);

  always_comb begin
    done_d = done_q;
    ie_d   = ie_q;
    ge_d   = ge_q;
    sel_d  = sel_q;
    if (ctrl_we_o) begin
      if (!reg_wdata[B_DONE]) done_d = 1'b0;
      ie_d  = reg_wdata[B_IE];
      ge_d  = reg_wdata[B_GE +: 2];
      sel_d = reg_wdata[B_SEL +: SEL_W];
    end
    if (cap_i) done_d = 1'b1;
    gen_d  = gen_en ? cnt_i : gen_q;
    rcap_d = cap_i  ? cnt_i : rcap_q;
    fcap_d = cap_i  ? cnt_i : fcap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ie_q   <= 1'b0;
      ge_q   <= 2'b00;
      sel_q  <= '0;
      gen_q  <= '0;
      rcap_q <= '0;
      fcap_q <= '0;
    end else begin
      done_q <= done_d;
      ie_q   <= ie_d;
      ge_q   <= ge_d;
      sel_q  <= sel_d;
      gen_q  <= gen_d;
      rcap_q <= rcap_d;
      fcap_q <= fcap_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[B_START]         = armed_i;
        reg_rdata[B_DONE]          = done_q;
        reg_rdata[B_IE]            = ie_q;
        reg_rdata[B_GE +: 2]       = ge_q;
        reg_rdata[B_SEL +: SEL_W]  = sel_q;
      end
      A_GEN:   reg_rdata = gen_q;
      A_RISE:  reg_rdata = rcap_q;
      default: reg_rdata = fcap_q;
    endcase
  end

  assign sel_o  = sel_q;
  assign done_o = done_q;
  assign gen_o  = gen_q;
  assign rcap_o = rcap_q;
  assign fcap_o = fcap_q;
  assign irq_o  = done_q & ie_q;
endmodule

// File: rtl/pwcap_top.sv
`timescale 1ns/1ps
module pwcap_top
  import pwcap_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [CNT_W-1:0]   reg_wdata,
  output logic [CNT_W-1:0]   reg_rdata,
  output logic               irq_o
);
  localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic             rise_w, fall_w, cap_w, ctrl_we_w, done_w;
  logic [SEL_W-1:0] sel_w;
  logic [CNT_W-1:0] gen_w, rcap_w, fcap_w;
  arm_state_e       st_w;

  pwcap_sync_edge #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .STAGES(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .sel_i(sel_w),
    .rise_o(rise_w), .fall_o(fall_w)
  );

  pwcap_seq u_seq (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_w), .fall_i(fall_w),
    .ctrl_we_i(ctrl_we_w), .wr_start_i(reg_wdata[B_START]),
    .st_o(st_w), .cap_o(cap_w)
  );

  pwcap_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .rise_i(rise_w), .fall_i(fall_w),
    .cap_i(cap_w), .armed_i(st_w != ST_IDLE), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ctrl_we_o(ctrl_we_w),
    .sel_o(sel_w), .done_o(done_w), .gen_o(gen_w), .rcap_o(rcap_w),
    .fcap_o(fcap_w), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );
endmodule

// File: rtl/pwcap_chk.sv
`timescale 1ns/1ps
module pwcap_chk
  import pwcap_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_i,
  input arm_state_e       st,
  input logic             rise,
  input logic             fall,
  input logic             cap,
  input logic             ctrl_we,
  input logic             done,
  input logic             irq,
  input logic [CNT_W-1:0] gen,
  input logic [CNT_W-1:0] rcap,
  input logic [CNT_W-1:0] fcap
);
  // R4
  cap_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (rcap == $past(cnt_i)) && (fcap == $past(cnt_i)));

  // R5
  done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> done && (st == ST_IDLE));

  // R5
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cap));

  // R3
  early_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WRISE && fall && !ctrl_we) |=> (st == ST_WRISE));

  // R7
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rcap) |-> $past(cap));

  // R9
  gen_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gen) |-> $past(rise || fall));

  // R6
  irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);
endmodule

bind pwcap_top pwcap_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .st(st_w), .rise(rise_w),
  .fall(fall_w), .cap(cap_w), .ctrl_we(ctrl_we_w), .done(done_w),
  .irq(irq_o), .gen(gen_w), .rcap(rcap_w), .fcap(fcap_w)
);

// File: tb/pwcap_top_tb.sv
`timescale 1ns/1ps
module pwcap_top_tb;
  localparam int CW = 12;
  localparam int NS = 4;

  logic          clk, rst_n;
  logic [CW-1:0] cnt;
  logic [NS-1:0] src;
  logic          reg_we;
  logic [1:0]    reg_addr;
  logic [CW-1:0] wdata, rdata;
  logic          irq;

  int total = 0, fails = 0;

  // bench model
  int            m_state;  // 0 idle, 1 wait rise, 2 wait fall
  bit            m_done, m_ie;
  logic [1:0]    m_ge, m_sel;
  logic [CW-1:0] m_gen, m_rise, m_fall;

  pwcap_top #(.CNT_W(CW), .NUM_SRC(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .src_i(src), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= 12'hFE0;
    else        cnt <= cnt + 1'b1;

  function automatic logic [CW-1:0] exp_ctrl();
    return CW'({m_sel, m_ge, m_ie, m_done, (m_state != 0)});
  endfunction

  task automatic chk(string tag, logic [CW-1:0] got, logic [CW-1:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic edge_model(int idx, bit v, logic [CW-1:0] c);
    logic [CW-1:0] val;
    val = c + 2'd2;
    if (idx != int'(m_sel)) return;
    if (v && m_ge[0])  m_gen = val;
    if (!v && m_ge[1]) m_gen = val;
    if (v && m_state == 1) m_state = 2;
    else if (!v && m_state == 2) begin
      m_rise = val; m_fall = val; m_done = 1'b1; m_state = 0;
    end
  endtask

  task automatic set_src(int idx, bit v);
    @(negedge clk);
    if (src[idx] != v) begin
      src[idx] = v;
      edge_model(idx, v, cnt);
    end
  endtask

  task automatic pulse(int idx, int w);
    set_src(idx, 1'b1);
    repeat (w - 1) @(negedge clk);
    set_src(idx, 1'b0);
  endtask

  task automatic wr_ctrl(bit st, bit dn, bit ie, logic [1:0] ge, logic [1:0] sel);
    repeat (4) @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0;
    wdata = CW'({sel, ge, ie, dn, st});
    if (!st) m_state = 0;
    else if (m_state == 0) m_state = 1;
    if (!dn) m_done = 1'b0;
    m_ie = ie; m_ge = ge; m_sel = sel;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [CW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = rdata;
  endtask

  task automatic check_all(string tag);
    logic [CW-1:0] d;
    string t;
    repeat (4) @(negedge clk);
    t = (tag == "") ? "R5 control" : tag;
    rd(2'd0, d); chk({t, " ctrl"}, d, exp_ctrl());
    t = (tag == "") ? "R9 general" : tag;
    rd(2'd1, d); chk({t, " gen"}, d, m_gen);
    t = (tag == "") ? "R4 rise" : tag;
    rd(2'd2, d); chk({t, " rise"}, d, m_rise);
    t = (tag == "") ? "R4 fall" : tag;
    rd(2'd3, d); chk({t, " fall"}, d, m_fall);
    t = (tag == "") ? "R6 irq" : tag;
    chk({t, " irq"}, CW'(irq), CW'(m_done & m_ie));
  endtask

  initial begin
    #(4ns * 200000);
    fails++; total++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    src = '0; reg_we = 1'b0; reg_addr = 2'd0; wdata = '0;
    m_state = 0; m_done = 0; m_ie = 0; m_ge = 2'b00; m_sel = 2'd0;
    m_gen = '0; m_rise = '0; m_fall = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    check_all("R1 reset");

    // R2: arm with source 1, both-edge general capture, irq enabled
    wr_ctrl(1'b0, 1'b0, 1'b1, 2'b11, 2'd1);
    set_src(1, 1'b1);                    // rise while idle
    wr_ctrl(1'b1, 1'b0, 1'b1, 2'b11, 2'd1);
    check_all("R2 arm");
    // R3: fall before rise while armed is ignored
    set_src(1, 1'b0);
    check_all("R3 early fall");
    // R4 / R5 / R6: full pulse completes the capture
    pulse(1, 3);
    check_all("R4 R5 capture");
    // R6: writing 1 to done keeps it, writing 0 clears it
    wr_ctrl(1'b0, 1'b1, 1'b1, 2'b11, 2'd1);
    check_all("R6 done write one");
    wr_ctrl(1'b0, 1'b0, 1'b1, 2'b11, 2'd1);
    check_all("R6 done clear");
    // R10: further pulse after completion leaves capture registers
    pulse(1, 2);
    check_all("R10 no rearm");
    // R8: unselected source has no effect
    pulse(0, 4);
    pulse(3, 2);
    check_all("R8 unselected");
    // R7: abandon between rise and fall
    wr_ctrl(1'b1, 1'b0, 1'b1, 2'b11, 2'd1);
    set_src(1, 1'b1);
    wr_ctrl(1'b0, 1'b0, 1'b1, 2'b11, 2'd1);
    set_src(1, 1'b0);
    check_all("R7 abandon");
    // R9: rising-only and none filters
    wr_ctrl(1'b0, 1'b0, 1'b1, 2'b01, 2'd1);
    pulse(1, 5);
    check_all("R9 rising only");
    wr_ctrl(1'b0, 1'b0, 1'b1, 2'b00, 2'd1);
    pulse(1, 2);
    check_all("R9 none");

    // constrained random phase
    for (int it = 0; it < 80; it++) begin
      int op;
      op = $urandom % 7;
      case (op)
        0: pulse(int'(m_sel), 1 + ($urandom % 5));
        1: pulse((int'(m_sel) + 1 + ($urandom % 3)) % NS, 1 + ($urandom % 4));
        2: wr_ctrl(1'b1, m_done, m_ie, m_ge, m_sel);
        3: wr_ctrl(1'b0, m_done, m_ie, m_ge, m_sel);
        4: wr_ctrl(m_state != 0, 1'b0, 1'($urandom % 2), m_ge, m_sel);
        5: begin
          for (int k = 0; k < NS; k++) set_src(k, 1'b0);
          wr_ctrl(m_state != 0, m_done, m_ie, 2'($urandom % 4), 2'($urandom % 4));
        end
        default: set_src(int'(m_sel), ~src[m_sel]);
      endcase
      check_all("");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule